// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Read-to-Acknowledge

This block gathers six external interrupt pins and one active-low non-maskable pin. Each external pin is synchronised through two flip-flops. It then passes a width qualifier that rejects pulses shorter than a parameterised number of clock cycles. A qualified transition into the pin's active level latches a request bit for that source. A 3-bit level is kept for each source, where level 0 disables the source. Among the pending, enabled sources, the one with the highest level wins, and on equal levels the lower index wins.

The winning source index and its level are offered on a valid/ready acknowledge port. `ack_valid` is high whenever an enabled request is pending. The acknowledge port exerts no back-pressure on the pins: requests keep collecting while `ack_ready` is low. A transfer takes place on any clock edge where `ack_valid` and `ack_ready` are both high, and it clears the winner's request bit. This holds whoever asserts `ack_ready`, the interrupt sequence or ordinary software, so a careless read loses that interrupt. `ack_ready` with `ack_valid` low has no effect. Software can also set or clear any request bit directly. An interrupt line to the CPU is raised only when the winner's level is strictly above the CPU's current priority level.

The non-maskable pin has no enable. Its synchronised level is readable. A stop-mode control bit is held at 0 while that level is low, so a stop request is refused.

Top module: `irqc_top`

## Requirements
- R1: After reset, `ack_valid`, `irq_out`, `nmi_req` and `stop_mode` are 0, `nmi_level` is 1, all levels are 0 and all polarities are active-high.
- R2: An external pin that stays at its active level for at least MIN_CYC consecutive cycles latches that source's request bit. A pulse shorter than MIN_CYC cycles latches nothing.
- R3: `cfg_pol`=1 selects active-high and 0 selects active-low. Writing a polarity under which the pin's qualified level is already active latches that source's request bit.
- R4: A pending source whose level is 0 is never offered, and its bit stays pending. Once its level is raised above 0, it is offered.
- R5: The winner is the pending source with the highest nonzero level, with ties going to the lower index. `ack_id` is the source index (0 to 5) and `ack_lvl` is its level.
- R6: An edge with `ack_valid` and `ack_ready` both high clears the winner's request bit. `ack_ready` while `ack_valid` is low changes nothing.
- R7: `irq_out` is 1 exactly when `ack_valid` is 1 and `ack_lvl` is strictly greater than `cpu_ipl`.
- R8: A write with `req_wr_en` sets bit `req_wr_idx` when `req_wr_val`=1 and clears it when `req_wr_val`=0. When a set and a clear reach the same bit on the same edge, the set wins.
- R9: A low level on `nmi_pin_n` lasting at least one clock sets `nmi_req`, with no mask. `nmi_req` stays set until `nmi_ack`, and a new low level wins over a simultaneous `nmi_ack`.
- R10: `nmi_level` shows the `nmi_pin_n` level two clock edges after it changes.
- R11: `stop_wr` loads `stop_wdata` into `stop_mode` only while `nmi_level` is 1. While `nmi_level` is 0, `stop_mode` is forced to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 6 | External interrupt pins |
| nmi_pin_n | input | 1 | Non-maskable pin, active low |
| cfg_we | input | 1 | Write level and polarity of one source |
| cfg_idx | input | 3 | Source index for the configuration write |
| cfg_level | input | 3 | Level to write, 0 disables the source |
| cfg_pol | input | 1 | Polarity to write, 1 is active-high |
| req_wr_en | input | 1 | Software write of one request bit |
| req_wr_idx | input | 3 | Source index for the request write |
| req_wr_val | input | 1 | Request bit value to write |
| cpu_ipl | input | 3 | CPU processor priority level |
| irq_out | output | 1 | Interrupt line to the CPU |
| ack_valid | output | 1 | An enabled request is pending |
| ack_ready | input | 1 | Acknowledge read, clears the winner |
| ack_id | output | 3 | Index of the winning source |
| ack_lvl | output | 3 | Level of the winning source |
| nmi_req | output | 1 | Latched non-maskable request |
| nmi_ack | input | 1 | Clears `nmi_req` |
| nmi_level | output | 1 | Synchronised non-maskable pin level |
| stop_wr | input | 1 | Write the stop-mode bit |
| stop_wdata | input | 1 | Stop-mode value to write |
| stop_mode | output | 1 | Stop-mode control bit |

## Verification
Configuration writes, request writes and acknowledge transfers land on the next edge, and `ack_*` and `irq_out` follow combinationally. `cpu_ipl` acts on `irq_out` within the same cycle. A pin held active is latched MIN_CYC+3 edges after the change: two to synchronise, MIN_CYC to qualify and one to latch. The non-maskable level appears after two edges, and `nmi_req` and the forced stop bit after three. The bench drives and samples 2 ns after a rising edge and only samples once these counts have elapsed. For pin pulses it waits a generous margin and then checks that the state has settled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqc_sync2.sv
module irqc_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/irqc_pin_qual.sv
module irqc_pin_qual #(
  parameter int unsigned MIN_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic event_o
);
  localparam int unsigned CNT_W = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);

  logic             pin_s;
  logic             lvl_q;
  logic             act;
  logic             act_prev_q;
  logic [CNT_W-1:0] cnt_q;

  irqc_sync2 #(.RST_VAL(1'b0)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      cnt_q      <= '0;
      act_prev_q <= 1'b0;
    end else begin
      act_prev_q <= act;
      if (pin_s != lvl_q) begin
        if (cnt_q == LAST) begin
          lvl_q <= pin_s;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign act     = pol_i ? lvl_q : ~lvl_q;
  assign event_o = act & ~act_prev_q;
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 6,
  parameter int unsigned ID_W  = 3
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_i,
  output logic                   hit_o,
  output logic [ID_W-1:0]        id_o,
  output lvl_t                   lvl_o
);
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    lvl_o = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (pend_i[i] && (lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        hit_o = 1'b1;
        id_o  = ID_W'(i);
        lvl_o = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_EXT   = 6,
  parameter int unsigned MIN_CYC = 13,
  localparam int unsigned ID_W   = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic             nmi_pin_n,
  input  logic             cfg_we,
  input  logic [ID_W-1:0]  cfg_idx,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             cfg_pol,
  input  logic             req_wr_en,
  input  logic [ID_W-1:0]  req_wr_idx,
  input  logic             req_wr_val,
  input  logic [LVL_W-1:0] cpu_ipl,
  output logic             irq_out,
  output logic             ack_valid,
  input  logic             ack_ready,
  output logic [ID_W-1:0]  ack_id,
  output logic [LVL_W-1:0] ack_lvl,
  output logic             nmi_req,
  input  logic             nmi_ack,
  output logic             nmi_level,
  input  logic             stop_wr,
  input  logic             stop_wdata,
  output logic             stop_mode
);
  logic [N_EXT-1:0]       pend_q, pend_d, set_v, clr_v, ev_v;
  logic [N_EXT*LVL_W-1:0] lvl_q;
  logic [N_EXT-1:0]       pol_q;
  logic                   nmi_s, nmi_prev_q;
  lvl_t                   win_lvl;

  // per-pin synchroniser, width qualifier and edge detector
  for (genvar g = 0; g < int'(N_EXT); g++) begin : g_pin
    irqc_pin_qual #(.MIN_CYC(MIN_CYC)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (ext_pin[g]),
      .pol_i  (pol_q[g]),
      .event_o(ev_v[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[g*LVL_W +: LVL_W] <= '0;
        pol_q[g]                <= 1'b1;
      end else if (cfg_we && (cfg_idx == ID_W'(g))) begin
        lvl_q[g*LVL_W +: LVL_W] <= cfg_level;
        pol_q[g]                <= cfg_pol;
      end
    end
  end

  irqc_pick #(.N_SRC(N_EXT), .ID_W(ID_W)) u_pick (
    .pend_i(pend_q),
    .lvl_i (lvl_q),
    .hit_o (ack_valid),
    .id_o  (ack_id),
    .lvl_o (win_lvl)
  );

  assign ack_lvl = win_lvl;
  assign irq_out = ack_valid && (win_lvl > cpu_ipl);

  // request bits: sets beat clears on the same edge
  always_comb begin
    set_v = ev_v;
    clr_v = '0;
    for (int i = 0; i < int'(N_EXT); i++) begin
      if (ack_valid && ack_ready && (ack_id == ID_W'(i))) clr_v[i] = 1'b1;
      if (req_wr_en && (req_wr_idx == ID_W'(i))) begin
        if (req_wr_val) set_v[i] = 1'b1;
        else            clr_v[i] = 1'b1;
      end
    end
    pend_d = (pend_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // non-maskable path
  irqc_sync2 #(.RST_VAL(1'b1)) u_nmi_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (nmi_pin_n),
    .q_o  (nmi_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      nmi_req    <= 1'b0;
      stop_mode  <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_s;
      if (nmi_prev_q && !nmi_s) nmi_req <= 1'b1;
      else if (nmi_ack)         nmi_req <= 1'b0;
      if (!nmi_s)               stop_mode <= 1'b0;
      else if (stop_wr)         stop_mode <= stop_wdata;
    end
  end

  assign nmi_level = nmi_s;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ack_valid,
  input lvl_t       ack_lvl,
  input logic       irq_out,
  input lvl_t       cpu_ipl,
  input logic       nmi_level,
  input logic       nmi_req,
  input logic       nmi_ack,
  input logic       stop_mode,
  input logic       stop_wr,
  input logic       stop_wdata
);
  AST_OFFER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_lvl != '0)); // R4
  AST_IRQ_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (ack_valid && (ack_lvl > cpu_ipl))); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_valid |-> !irq_out); // R7
  AST_NMI_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_level) |=> nmi_req); // R9
  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_ack) |=> nmi_req); // R9
  AST_STOP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_level |=> !stop_mode); // R11
  AST_STOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_level && stop_wr) |=> (stop_mode == $past(stop_wdata))); // R11
endmodule

bind irqc_top irqc_checker u_chk (.*);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  localparam int MIN = 13;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ext_pin = '0;
  logic nmi_pin_n = 1'b1;
  logic cfg_we = 0, cfg_pol = 1, req_wr_en = 0, req_wr_val = 0;
  logic [2:0] cfg_idx = '0, cfg_level = '0, req_wr_idx = '0, cpu_ipl = '0;
  logic ack_ready = 0, nmi_ack = 0, stop_wr = 0, stop_wdata = 0;
  logic irq_out, ack_valid, nmi_req, nmi_level, stop_mode;
  logic [2:0] ack_id, ack_lvl;

  int checks = 0, fails = 0;
  bit m_pend [6];
  int m_lvl [6];

  always #10 clk = ~clk;

  irqc_top u_irqc_top (.*);

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int pick_model(int ipl);
    int bid = 0, bl = 0;
    for (int i = 0; i < 6; i++)
      if (m_pend[i] && m_lvl[i] > bl) begin bid = i; bl = m_lvl[i]; end
    // {valid, id, lvl, irq}
    return ((bl != 0) ? 256 : 0) | (bid << 4) | (bl << 1) | ((bl > ipl) ? 1 : 0);
  endfunction

  function automatic int observed();
    return (ack_valid ? 256 : 0) | ((ack_valid ? int'(ack_id) : 0) << 4)
           | (int'(ack_lvl) << 1) | int'(irq_out);
  endfunction

  task automatic cfg(int idx, int lvl, bit pol);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_level = 3'(lvl); cfg_pol = pol;
    tick(); cfg_we = 0;
    m_lvl[idx] = lvl;
  endtask

  task automatic swr(int idx, bit val);
    req_wr_en = 1; req_wr_idx = 3'(idx); req_wr_val = val;
    tick(); req_wr_en = 0;
    m_pend[idx] = val;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) begin m_pend[i] = 0; m_lvl[i] = 0; end
    tick(2); rst_n = 1; tick();
    // R1 reset state
    chk("R1 ack_valid", ack_valid, 0);
    chk("R1 irq_out", irq_out, 0);
    chk("R1 nmi_req", nmi_req, 0);
    chk("R1 nmi_level", nmi_level, 1);
    chk("R1 stop_mode", stop_mode, 0);

    // R2 width qualifier
    cfg(2, 3, 1);
    ext_pin[2] = 1; tick(MIN - 1); ext_pin[2] = 0; tick(MIN + 8);
    chk("R2 short pulse ignored", ack_valid, 0);
    ext_pin[2] = 1; tick(MIN); ext_pin[2] = 0; tick(MIN + 8);
    m_pend[2] = 1;
    chk("R2 min pulse latched", observed(), pick_model(0));
    // R6 acknowledge clears winner
    ack_ready = 1; tick(); ack_ready = 0; m_pend[2] = 0;
    chk("R6 ack clears", ack_valid, 0);

    // R3 polarity change latches
    cfg(4, 2, 1); tick(3);
    chk("R3 idle active-high", ack_valid, 0);
    cfg(4, 2, 0); tick(2); m_pend[4] = 1;
    chk("R3 polarity latch", observed(), pick_model(0));
    swr(4, 0);
    chk("R8 sw clear", ack_valid, 0);
    cfg(4, 2, 1); tick(3);
    chk("R3 back to active-high", ack_valid, 0);

    // R4 / R6 level 0 and ack without valid
    swr(5, 1);
    chk("R4 disabled not offered", ack_valid, 0);
    ack_ready = 1; tick(); ack_ready = 0;
    cfg(5, 1, 1);
    chk("R4 R6 kept pending", observed(), pick_model(0));

    // R5 tie goes to lower index
    cfg(1, 1, 1); swr(1, 1);
    chk("R5 tie lower index", observed(), pick_model(0));
    // R8 set wins over ack clear on same edge
    ack_ready = 1; req_wr_en = 1; req_wr_idx = 3'd1; req_wr_val = 1;
    tick(); ack_ready = 0; req_wr_en = 0;
    chk("R8 set beats clear", observed(), pick_model(0));
    // R7 strict compare
    cpu_ipl = 3'd1; #1;
    chk("R7 equal level no irq", irq_out, 0);
    cfg(1, 2, 1); chk("R7 above ipl", irq_out, 1);
    cpu_ipl = 3'd0;

    // clear everything for the random phase
    for (int i = 0; i < 6; i++) begin swr(i, 0); cfg(i, 0, 1); end
    chk("R8 all cleared", ack_valid, 0);

    // R5 R6 R7 R8 random phase
    for (int k = 0; k < 600; k++) begin
      int op = int'($urandom % 4);
      int idx = int'($urandom % 6);
      int win = (pick_model(int'(cpu_ipl)) >> 4) & 7;
      bit hit = (pick_model(int'(cpu_ipl)) & 256) != 0;
      case (op)
        0: begin
          req_wr_en = 1; req_wr_idx = 3'(idx); req_wr_val = 1'($urandom % 2);
        end
        1: begin
          cfg_we = 1; cfg_idx = 3'(idx); cfg_level = 3'($urandom % 8); cfg_pol = 1;
        end
        2: cpu_ipl = 3'($urandom % 8);
        default: begin
          ack_ready = 1;
          if ($urandom % 2 == 1) begin
            req_wr_en = 1; req_wr_idx = 3'(idx); req_wr_val = 1;
          end
        end
      endcase
      tick();
      if (ack_ready && hit) m_pend[win] = 0;
      if (req_wr_en) m_pend[req_wr_idx] = req_wr_val;
      if (cfg_we) m_lvl[cfg_idx] = int'(cfg_level);
      ack_ready = 0; req_wr_en = 0; cfg_we = 0;
      chk("R5 R6 R7 R8 random", observed(), pick_model(int'(cpu_ipl)));
    end

    // R9 one-clock low pulse
    nmi_pin_n = 0; tick(); nmi_pin_n = 1; tick(4);
    chk("R9 one-clock nmi latched", nmi_req, 1);
    tick(3); chk("R9 no mask, stays", nmi_req, 1);
    nmi_ack = 1; tick(); nmi_ack = 0;
    chk("R9 ack clears", nmi_req, 0);

    // R11 stop write, then R10 readback timing
    stop_wr = 1; stop_wdata = 1; tick(); stop_wr = 0;
    chk("R11 stop loaded", stop_mode, 1);
    nmi_pin_n = 0; tick();
    chk("R10 level after one edge", nmi_level, 1);
    tick();
    chk("R10 level after two edges", nmi_level, 0);
    tick();
    chk("R11 stop forced", stop_mode, 0);
    stop_wr = 1; stop_wdata = 1; tick(); stop_wr = 0;
    chk("R11 stop refused", stop_mode, 0);
    nmi_pin_n = 1; tick(3);
    chk("R9 held low latched", nmi_req, 1);
    stop_wr = 1; stop_wdata = 1; tick(); stop_wr = 0;
    chk("R11 stop accepted after release", stop_mode, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule